// File: doc/BRIEF.md
# CPU-Cycle Countdown Interrupt Timer

This block is a 16-bit down-counter for a cartridge memory mapper. It decrements once per CPU clock and raises an interrupt request when it underflows. Software loads the count through a byte-wide load port. The first write fills the upper byte and the second fills the lower byte. Both writes land in the running counter itself, and no separate reload value is kept.

A second write port, the control port, does three things. Bit 4 of the written value sets whether the counter runs or pauses. Any control write drops a pending interrupt request. Any control write also rewinds the byte pointer, so that the next load write goes to the upper byte.

On underflow from 0x0000 to 0x FFFF the counter stops itself and holds the request until software acknowledges it. Address decoding is reduced to the two write strobes `load_we` and `ctrl_we`, which share the 8-bit data bus `wdata`.

Top module: `cyc_irq_timer`

## Requirements
- R1: Load writes alternate between bytes. After reset, and after every pair of load writes, the next load write sets counter bits 15..8; the write after it sets bits 7..0.
- R2: A load write changes the live counter in the same clock edge, and the count continues from the new value. A cycle with a load write does not decrement.
- R3: Control data bit 4 is the run enable: 1 counts and 0 pauses. While paused the count holds its value.
- R4: While enabled, the count decreases by one on every clock. A count of N, enabled by a control write, raises the request N+1 clocks after that write's edge.
- R5: When an enabled count of 0x0000 decrements, it becomes 0xFFFF, the interrupt request is set and the enable clears.
- R6: The interrupt request stays asserted until a control write. Load writes do not clear it.
- R7: Any control write clears the interrupt request, and the request is low on the next cycle.
- R8: Any control write rewinds the byte pointer, so the next load write sets bits 15..8.
- R9: Reset clears the count to 0x0000, clears the enable and the request, and points the byte pointer at the upper byte.
- R10: If a control write falls in the same cycle as an underflow, the control write wins. The request stays clear, the enable takes the written bit 4, and the count still becomes 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; one count step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Write strobe for the two-step counter load |
| ctrl_we | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Write data shared by both strobes |
| irq_o | output | 1 | Interrupt request, active high by default |

## Verification
Every result here is registered once:
- A write captured at edge E shows its effect on the state right after E.
- The request line follows one edge after the state that causes it.
- A count of N enabled at edge E underflows at edge E+N+1.

The bench drives inputs at falling edges and samples `irq_o` at falling edges. It counts falling edges from the write's capture edge. For each case it checks the line low one cycle before the due cycle and high in the due cycle, so a timing error of one count in either direction is caught. Pause, live reload, pointer rewind and same-cycle priority are all observed as shifts in that due cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;

   typedef enum logic {
      IRQ_ACT_HIGH = 1'b0,
      IRQ_ACT_LOW  = 1'b1
   } irq_pol_e;

   function automatic int lanes_for(input int cnt_w, input int data_w);
      return (cnt_w + data_w - 1) / data_w;
   endfunction

   function automatic int ptr_width(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/timer_lane_seq.sv
module timer_lane_seq #(
   parameter int NLANE = 2,
   parameter int LW    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_we,
   input  logic          ctrl_we,
   output logic [LW-1:0] lane_o
);

   localparam logic [LW-1:0] TOP = LW'(NLANE - 1);

   logic [LW-1:0] lane_q;
   logic [LW-1:0] lane_d;

   always_comb begin
      lane_d = lane_q;
      if (ctrl_we) begin
         lane_d = TOP;
      end else if (load_we) begin
         lane_d = (lane_q == '0) ? TOP : lane_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= TOP;
      end else begin
         lane_q <= lane_d;
      end
   end

   assign lane_o = lane_q;

endmodule

// File: rtl/timer_core.sv
module timer_core #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int NLANE  = 2,
   parameter int LW     = 1,
   parameter int EN_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LW-1:0]     lane,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              en_o,
   output logic              wrap_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] cnt_step;
   logic             en_q;
   logic             en_d;
   logic             stepping;
   logic             wrap;

   assign stepping = en_q && !load_we;
   assign wrap     = stepping && (cnt_q == '0);
   assign cnt_step = stepping ? cnt_q - 1'b1 : cnt_q;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int LO = g * DATA_W;
      localparam int HI = ((LO + DATA_W) > CNT_W) ? CNT_W : (LO + DATA_W);
      logic hit;
      assign hit = load_we && (lane == LW'(g));
      assign cnt_d[HI-1:LO] = hit ? wdata[HI-LO-1:0] : cnt_step[HI-1:LO];
   end

   always_comb begin
      en_d = en_q;
      if (ctrl_we) begin
         en_d = wdata[EN_BIT];
      end else if (wrap) begin
         en_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         en_q  <= en_d;
      end
   end

   assign cnt_o  = cnt_q;
   assign en_o   = en_q;
   assign wrap_o = wrap;

endmodule

// File: rtl/timer_irq_flag.sv
module timer_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic ctrl_we,
   output logic pend_o
);

   logic pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (ctrl_we) begin
         pend_q <= 1'b0;
      end else if (wrap) begin
         pend_q <= 1'b1;
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
   import timer_pkg::*;
#(
   parameter int       CNT_W   = 16,
   parameter int       DATA_W  = 8,
   parameter int       EN_BIT  = 4,
   parameter irq_pol_e IRQ_POL = IRQ_ACT_HIGH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              irq_o
);

   localparam int NLANE = lanes_for(CNT_W, DATA_W);
   localparam int LW    = ptr_width(NLANE);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (EN_BIT >= DATA_W || EN_BIT < 0) begin : g_bad_en
      $error("EN_BIT must select a bit of wdata");
   end

   logic [LW-1:0]    lane_q;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             wrap;
   logic             irq_pend;

   timer_lane_seq #(
      .NLANE (NLANE),
      .LW    (LW)
   ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_we (load_we),
      .ctrl_we (ctrl_we),
      .lane_o  (lane_q)
   );

   timer_core #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .NLANE  (NLANE),
      .LW     (LW),
      .EN_BIT (EN_BIT)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_we (load_we),
      .ctrl_we (ctrl_we),
      .wdata   (wdata),
      .lane    (lane_q),
      .cnt_o   (cnt_q),
      .en_o    (en_q),
      .wrap_o  (wrap)
   );

   timer_irq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .ctrl_we (ctrl_we),
      .pend_o  (irq_pend)
   );

   if (IRQ_POL == IRQ_ACT_LOW) begin : g_irq_low
      assign irq_o = ~irq_pend;
   end else begin : g_irq_high
      assign irq_o = irq_pend;
   end

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
   parameter int CNT_W = 16,
   parameter int NLANE = 2,
   parameter int LW    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_we,
   input logic             ctrl_we,
   input logic             irq_pend,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic [LW-1:0]    lane
);

   localparam logic [LW-1:0] TOP = LW'(NLANE - 1);

   // R7
   a_r7_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> !irq_pend);

   // R6
   a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !ctrl_we) |=> irq_pend);

   // R5
   a_r5_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> ($past(cnt) == '0 && $past(en)));

   // R5
   a_r5_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> (!en && cnt == '1));

   // R3
   a_r3_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load_we) |=> cnt == $past(cnt));

   // R4
   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load_we && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

   // R8
   a_r8_ctrl_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> lane == TOP);

   // R1
   a_r1_lane_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (load_we && !ctrl_we && lane != '0) |=> lane == LW'($past(lane) - 1'b1));

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
   .CNT_W (CNT_W),
   .NLANE (NLANE),
   .LW    (LW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_we  (load_we),
   .ctrl_we  (ctrl_we),
   .irq_pend (irq_pend),
   .cnt      (cnt_q),
   .en       (en_q),
   .lane     (lane_q)
);

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_we = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cyc_irq_timer i_cyc_irq_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_we (load_we),
      .ctrl_we (ctrl_we),
      .wdata   (wdata),
      .irq_o   (irq_o)
   );

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s irq actual %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic ld(input logic [7:0] v);
      load_we = 1'b1; wdata = v;
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic ctl(input logic [7:0] v);
      ctrl_we = 1'b1; wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // request due n cycles after the last write's capture edge
   task automatic expect_irq(input string req, input int n);
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         if (i == n - 1) check(req, irq_o, 1'b0);
         if (i == n)     check(req, irq_o, 1'b1);
      end
   endtask

   task automatic t_reset();
      check("R9 reset", irq_o, 1'b0);
      idle(40);
      check("R9 idle after reset", irq_o, 1'b0);
      ctl(8'h10);                       // count 0 from reset
      expect_irq("R9 reset count zero", 1);
   endtask

   task automatic t_sticky();
      idle(20);
      check("R6 held", irq_o, 1'b1);
      ld(8'h00);
      check("R6 load keeps irq", irq_o, 1'b1);
      ctl(8'h00);
      check("R7 ctrl clears", irq_o, 1'b0);
   endtask

   task automatic t_basic();
      ld(8'h00); ld(8'h05); ctl(8'h10);
      expect_irq("R4 count 5", 6);
   endtask

   task automatic t_high();
      ctl(8'h00);
      ld(8'h01); ld(8'h00); ctl(8'h10);
      expect_irq("R1 high byte 0x0100", 257);
   endtask

   task automatic t_autodis();
      ld(8'h00); ld(8'h04); idle(3); ctl(8'h10);
      expect_irq("R5 stopped after wrap", 5);
   endtask

   task automatic t_toggle();
      ctl(8'h00);
      ld(8'h12); ctl(8'h00);
      ld(8'h00); ld(8'h03); ctl(8'h10);
      expect_irq("R8 pointer rewind", 4);
   endtask

   task automatic t_pause();
      ctl(8'h00);
      ld(8'h00); ld(8'h06); ctl(8'h10);
      idle(2);
      ctl(8'hEF);                       // bit 4 clear: pause at count 3
      idle(30);
      check("R3 paused", irq_o, 1'b0);
      ctl(8'h10);
      expect_irq("R3 resume", 4);
   endtask

   task automatic t_live();
      ctl(8'h00);
      ld(8'h01); ld(8'h00); ctl(8'h10);
      idle(10);
      ld(8'h00); ld(8'h02);
      expect_irq("R2 live reload", 3);
   endtask

   task automatic t_prio();
      ctl(8'h00);
      ld(8'h00); ld(8'h02); ctl(8'h10);
      idle(2);
      ctl(8'h00);                       // lands on the wrap edge
      check("R10 ctrl wins, irq clear", irq_o, 1'b0);
      idle(20);
      check("R10 enable off stays quiet", irq_o, 1'b0);
      ld(8'h00); ld(8'h03); ctl(8'h10);
      idle(3);
      ctl(8'h10);                       // wrap edge again, enable kept
      check("R10 ctrl wins, irq clear", irq_o, 1'b0);
      expect_irq("R10 enable kept from 0xFFFF", 65536);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_sticky();
      t_basic();
      t_high();
      t_autodis();
      t_toggle();
      t_pause();
      t_live();
      t_prio();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R4 actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule